// File: doc/BRIEF.md
# PS/2 Keyboard Frame Receiver

This block takes the open-collector clock and data lines of a PS/2 keyboard, brings them into the system clock domain and hands one received byte to the host per frame. Every incoming keyboard clock pulse is resynchronised by a flop chain that updates only on the rising system clock edge. As a result, a keyboard edge that lands on a falling system edge is still seen. Each falling pulse is then counted.

Two jobs stay separate. An 8-bit shift register only loads the pulses that carry the data bits, least significant bit first. A separate pulse counter, set by the host to a pulse count, decides when a frame has ended. So the end of eight shifts never closes a frame. With an optional tail mode the start, parity and stop bits are also kept beside the byte.

The byte is held behind an interrupt until the host acknowledges it. The host can hold the keyboard clock low to inhibit the keyboard or to open a transfer towards it. If the clock goes quiet in the middle of a frame, the receiver drops the partial frame.

Top module: `ps2_frame_rx`

## Requirements
- R1: After reset, `irq_o`, `rx_byte_o`, `rx_tail_o` and `kbd_clk_pull_o` are all 0.
- R2: Frame pulses are numbered from 0, the start bit. The data bits on pulses 1 to 8 are assembled into `rx_byte_o` with pulse 1 in bit 0 and pulse 8 in bit 7.
- R3: The interrupt is raised only after the falling pulse whose number equals `frame_pulses_i`, counted from 1 (11 for a standard frame). It is not raised after the 8th data shift or after any earlier pulse.
- R4: `frame_pulses_i` is programmable. With a value of 12, no interrupt follows the 11th pulse and one follows the 12th, carrying the same data bits.
- R5: While `irq_o` is 1 and `ack_i` is 0, `irq_o` stays 1 and `rx_byte_o` does not change. A one-cycle `ack_i` clears `irq_o` on the next cycle.
- R6: A frame that completes while `irq_o` is already 1 is discarded, and the held byte is kept.
- R7: With `tail_en_i` = 1, `rx_tail_o` = {pulse 10 bit, pulse 9 bit, pulse 0 bit}, that is {stop, parity, start}. With `tail_en_i` = 0, `rx_tail_o` is 0.
- R8: If no falling pulse arrives for more than `TIMEOUT_CYC` system cycles in the middle of a frame, the pulse count returns to 0. The next frame is then received correctly.
- R9: `kbd_clk_pull_o` follows `hold_i` one cycle later. While `hold_i` is 1, the pulse count is held at 0, so a partial frame and the self-made clock edge are both discarded.
- R10: A keyboard clock change driven on a falling system clock edge, with a low phase of at least `SYNC_STAGES`+1 system cycles, is counted exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| kbd_clk_i | input | 1 | Raw keyboard clock line |
| kbd_dat_i | input | 1 | Raw keyboard data line |
| frame_pulses_i | input | CNT_W | Pulses per frame, valid range 9 to 15 |
| tail_en_i | input | 1 | Keep start, parity and stop bits |
| hold_i | input | 1 | Host request to hold the keyboard clock low |
| ack_i | input | 1 | Interrupt acknowledge |
| kbd_clk_pull_o | output | 1 | Drive the keyboard clock line low |
| irq_o | output | 1 | Frame received |
| rx_byte_o | output | 8 | Received data byte |
| rx_tail_o | output | 3 | {stop, parity, start} in tail mode |

## Verification
The embedded assertions check the following on every cycle:
- the interrupt hold and acknowledge behaviour and the stability of the byte while it is pending;
- that every interrupt is preceded by a frame-complete pulse;
- that a shift stores the data value sampled on that pulse;
- that a clock hold leaves the pulse count at zero;
- that the idle counter stays within its bound.

Other behaviours only the bench scenarios can show:
- bit order in the assembled byte;
- that the interrupt waits for the programmed pulse count rather than the eighth shift;
- the tail contents;
- dropping a frame that arrives while one is pending;
- recovery after a mid-frame stall or a host clock hold.

// File: rtl/ps2_rx_pkg.sv
package ps2_rx_pkg;
  localparam int DATA_BITS  = 8;
  localparam int TAIL_BITS  = 3;
  localparam int POS_START  = 0;
  localparam int POS_DFIRST = 1;
  localparam int POS_DLAST  = 8;
  localparam int POS_PARITY = 9;
  localparam int POS_STOP   = 10;
  typedef logic [DATA_BITS-1:0] rx_byte_t;
  typedef logic [TAIL_BITS-1:0] rx_tail_t;
endpackage

// File: rtl/ps2_edge_sync.sv
module ps2_edge_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_clk_i,
  input  logic raw_dat_i,
  output logic fall_o,
  output logic dat_o
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] csr_q;
  logic [SYNC_STAGES-1:0] dsr_q;
  logic                   prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      csr_q[0] <= 1'b1;
      dsr_q[0] <= 1'b1;
    end else begin
      csr_q[0] <= raw_clk_i;
      dsr_q[0] <= raw_dat_i;
    end
  end

  for (genvar i = 1; i < SYNC_STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        csr_q[i] <= 1'b1;
        dsr_q[i] <= 1'b1;
      end else begin
        csr_q[i] <= csr_q[i-1];
        dsr_q[i] <= dsr_q[i-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= csr_q[LAST];
  end

  assign fall_o = prev_q & ~csr_q[LAST];
  assign dat_o  = dsr_q[LAST];

  // R10
  single_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fall_o |=> !fall_o);
endmodule

// File: rtl/ps2_pulse_cnt.sv
module ps2_pulse_cnt #(
  parameter int CNT_W       = 4,
  parameter int TIMEOUT_CYC = 4000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fall_i,
  input  logic             hold_i,
  input  logic [CNT_W-1:0] target_i,
  output logic [CNT_W-1:0] idx_o,
  output logic             done_o
);
  localparam int TW = $clog2(TIMEOUT_CYC + 1);

  logic [CNT_W-1:0] idx_q, idx_d;
  logic [TW-1:0]    idle_q, idle_d;
  logic             stall;

  assign stall = (idle_q == TW'(TIMEOUT_CYC));

  always_comb begin
    idx_d  = idx_q;
    idle_d = idle_q;
    done_o = 1'b0;
    if (hold_i) begin
      idx_d  = '0;
      idle_d = '0;
    end else if (fall_i) begin
      idle_d = '0;
      if (idx_q == target_i - CNT_W'(1)) begin
        idx_d  = '0;
        done_o = 1'b1;
      end else begin
        idx_d = idx_q + CNT_W'(1);
      end
    end else if (idx_q != '0) begin
      if (stall) begin
        idx_d  = '0;
        idle_d = '0;
      end else begin
        idle_d = idle_q + TW'(1);
      end
    end else begin
      idle_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      idle_q <= '0;
    end else begin
      idx_q  <= idx_d;
      idle_q <= idle_d;
    end
  end

  assign idx_o = idx_q;

  // R9
  hold_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold_i |=> (idx_q == '0));
  // R8
  idle_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_q <= TW'(TIMEOUT_CYC)));
endmodule

// File: rtl/ps2_shift_unit.sv
module ps2_shift_unit
  import ps2_rx_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fall_i,
  input  logic             dat_i,
  input  logic [CNT_W-1:0] idx_i,
  input  logic             tail_en_i,
  output rx_byte_t         sh_o,
  output rx_tail_t         tail_o
);
  rx_byte_t sh_q, sh_d;
  rx_tail_t tail_q, tail_d;
  logic     shift_en;

  assign shift_en = fall_i && (idx_i >= CNT_W'(POS_DFIRST)) &&
                    (idx_i <= CNT_W'(POS_DLAST));

  always_comb begin
    sh_d   = sh_q;
    tail_d = tail_q;
    if (shift_en) sh_d = {dat_i, sh_q[DATA_BITS-1:1]};
    if (fall_i) begin
      if (idx_i == CNT_W'(POS_START))
        tail_d = {2'b00, tail_en_i & dat_i};
      else if (tail_en_i && idx_i == CNT_W'(POS_PARITY))
        tail_d[1] = dat_i;
      else if (tail_en_i && idx_i == CNT_W'(POS_STOP))
        tail_d[2] = dat_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      tail_q <= '0;
    end else begin
      sh_q   <= sh_d;
      tail_q <= tail_d;
    end
  end

  assign sh_o   = sh_q;
  assign tail_o = tail_q;

  // R2
  shift_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> (sh_q[DATA_BITS-1] == $past(dat_i)));
endmodule

// File: rtl/ps2_frame_rx.sv
module ps2_frame_rx
  import ps2_rx_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 4,
  parameter int TIMEOUT_CYC = 4000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             kbd_clk_i,
  input  logic             kbd_dat_i,
  input  logic [CNT_W-1:0] frame_pulses_i,
  input  logic             tail_en_i,
  input  logic             hold_i,
  input  logic             ack_i,
  output logic             kbd_clk_pull_o,
  output logic             irq_o,
  output logic [7:0]       rx_byte_o,
  output logic [2:0]       rx_tail_o
);
  logic             fall, sdat, done, done_q;
  logic [CNT_W-1:0] idx;
  rx_byte_t         sh, byte_q, byte_d;
  rx_tail_t         tail, tail_q, tail_d;
  logic             irq_q, irq_d, pull_q;

  ps2_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .raw_clk_i(kbd_clk_i), .raw_dat_i(kbd_dat_i),
    .fall_o(fall), .dat_o(sdat));

  ps2_pulse_cnt #(.CNT_W(CNT_W), .TIMEOUT_CYC(TIMEOUT_CYC)) u_cnt (
    .clk(clk), .rst_n(rst_n), .fall_i(fall), .hold_i(hold_i),
    .target_i(frame_pulses_i), .idx_o(idx), .done_o(done));

  ps2_shift_unit #(.CNT_W(CNT_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .fall_i(fall), .dat_i(sdat), .idx_i(idx),
    .tail_en_i(tail_en_i), .sh_o(sh), .tail_o(tail));

  always_comb begin
    irq_d  = irq_q;
    byte_d = byte_q;
    tail_d = tail_q;
    if (ack_i) irq_d = 1'b0;
    if (done_q && (!irq_q || ack_i)) begin
      irq_d  = 1'b1;
      byte_d = sh;
      tail_d = tail;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      irq_q  <= 1'b0;
      byte_q <= '0;
      tail_q <= '0;
      pull_q <= 1'b0;
    end else begin
      done_q <= done;
      irq_q  <= irq_d;
      byte_q <= byte_d;
      tail_q <= tail_d;
      pull_q <= hold_i;
    end
  end

  assign irq_o          = irq_q;
  assign rx_byte_o      = byte_q;
  assign rx_tail_o      = tail_q;
  assign kbd_clk_pull_o = pull_q;

  // R5
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q && !ack_i) |=> (irq_q && $stable(byte_q)));
  // R5
  irq_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && !done_q) |=> !irq_q);
  // R3
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_q) |-> $past(done_q));
endmodule

// File: tb/sim_ps2_frame_rx.sv
module sim_ps2_frame_rx;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       kbd_clk = 1'b1, kbd_dat = 1'b1;
  logic [3:0] frame_pulses = 4'd11;
  logic       tail_en = 1'b0, hold = 1'b0, ack = 1'b0;
  logic       pull, irq;
  logic [7:0] rx_byte;
  logic [2:0] rx_tail;
  logic       line_clk;
  int         n_cmp = 0, n_bad = 0;
  bit         finished = 0;

  always #5 clk = ~clk;
  assign line_clk = kbd_clk & ~pull;

  ps2_frame_rx #(.TIMEOUT_CYC(300)) u0 (
    .clk(clk), .rst_n(rst_n), .kbd_clk_i(line_clk), .kbd_dat_i(kbd_dat),
    .frame_pulses_i(frame_pulses), .tail_en_i(tail_en), .hold_i(hold),
    .ack_i(ack), .kbd_clk_pull_o(pull), .irq_o(irq), .rx_byte_o(rx_byte),
    .rx_tail_o(rx_tail));

  // {tail_en, data}
  localparam logic [8:0] VEC [6] = '{9'h0A5, 9'h001, 9'h180, 9'h1FF, 9'h000, 9'h13C};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    kbd_dat = b;
    cyc(10);
    kbd_clk = 1'b0;
    cyc(20);
    kbd_clk = 1'b1;
    cyc(10);
  endtask

  function automatic logic [10:0] mkframe(input logic [7:0] d);
    return {1'b1, ~^d, d, 1'b0};
  endfunction

  task automatic send_frame(input logic [7:0] d);
    logic [10:0] f;
    f = mkframe(d);
    for (int i = 0; i < 11; i++) send_bit(f[i]);
  endtask

  task automatic do_ack;
    ack = 1'b1;
    cyc(1);
    ack = 1'b0;
    cyc(1);
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    n_cmp++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [7:0] d;
    logic [10:0] f;
    cyc(3);
    rst_n = 1'b1;
    cyc(2);
    // R1 reset state
    chk("R1 irq", irq, 0);
    chk("R1 byte", rx_byte, 0);
    chk("R1 tail", rx_tail, 0);
    chk("R1 pull", pull, 0);

    // table walk: R2, R7, R5, R10 (inputs change on falling system edge)
    for (int v = 0; v < 6; v++) begin
      d = VEC[v][7:0];
      tail_en = VEC[v][8];
      send_frame(d);
      chk("R2 irq raised", irq, 1);
      chk("R2 byte", rx_byte, d);
      chk("R7 tail", rx_tail, tail_en ? {1'b1, ~^d, 1'b0} : 3'b000);
      do_ack();
      chk("R5 ack clears", irq, 0);
    end
    tail_en = 1'b0;

    // R3: no irq after 8 data shifts or 10 pulses
    d = 8'h5A;
    f = mkframe(d);
    for (int i = 0; i < 9; i++) send_bit(f[i]);
    chk("R3 no irq after 8 shifts", irq, 0);
    send_bit(f[9]);
    chk("R3 no irq after 10 pulses", irq, 0);
    send_bit(f[10]);
    chk("R3 irq at 11th", irq, 1);
    chk("R3 byte", rx_byte, d);

    // R5 hold while pending, R6 drop of second frame
    cyc(50);
    chk("R5 irq held", irq, 1);
    send_frame(8'hC3);
    chk("R6 irq still", irq, 1);
    chk("R6 byte kept", rx_byte, d);
    do_ack();
    chk("R5 cleared", irq, 0);

    // R4: programmable length 12
    frame_pulses = 4'd12;
    d = 8'h96;
    f = mkframe(d);
    for (int i = 0; i < 11; i++) send_bit(f[i]);
    chk("R4 no irq at 11", irq, 0);
    send_bit(1'b1);
    chk("R4 irq at 12", irq, 1);
    chk("R4 byte", rx_byte, d);
    do_ack();
    frame_pulses = 4'd11;

    // R8: stall mid-frame then full frame
    for (int i = 0; i < 5; i++) send_bit(1'b0);
    cyc(400);
    chk("R8 no irq", irq, 0);
    send_frame(8'h3E);
    chk("R8 irq", irq, 1);
    chk("R8 byte", rx_byte, 8'h3E);
    do_ack();

    // R9: host hold discards partial frame
    for (int i = 0; i < 3; i++) send_bit(1'b1);
    hold = 1'b1;
    cyc(2);
    chk("R9 pull on", pull, 1);
    cyc(100);
    hold = 1'b0;
    cyc(2);
    chk("R9 pull off", pull, 0);
    cyc(20);
    chk("R9 no irq", irq, 0);
    send_frame(8'h71);
    chk("R9 irq", irq, 1);
    chk("R9 byte", rx_byte, 8'h71);
    do_ack();

    finish_run();
  end
endmodule